// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Bank

This block holds the per-channel control/status word of a multi-channel DMA controller and the interrupt summary for all channels. A host port writes and reads 32-bit words. Each word mixes write-one-to-clear status flags with control bits that are loaded from the written value. The channel engines report what happens to them through single-cycle event pulses: start, end, end-of-receive, stop, request-after-start and bus error. Each engine also drives a level that shows whether its request is pending.

The block drives control levels back to each engine: run, no-descriptor-fetch, end-of-receive stop enable, end-of-receive jump enable and compare status. It also sends each engine a one-cycle launch pulse, with a flag that says whether a descriptor must be fetched first. One interrupt line collects every channel's gated sources. A summary word at a fixed address shows which channels are interrupting.

Addresses are word indices. Index `c` below `NUM_CH` selects channel `c`. Index `SUM_ADDR` selects the summary. Any other index reads as zero.

Top module: `dma_chan_status_bank`

## Requirements
- R1: After reset every channel word reads 0x00000008 (only the stopped flag, bit 3), the summary reads 0 and `irq` is low.
- R2: A write loads bits 31..26 and bit 23 of the channel word from the written value; bits 22, 24, 25 and every bit outside the status set always read as 0.
- R3: Writing 1 to bit 0 (bus error), bit 1 (start), bit 2 (end) or bit 9 (end-of-receive) clears that flag; writing 0 keeps it; bits 3, 4 and 10 are not cleared by this path.
- R4: Bit 8 of a channel read equals that channel's `req_active` input at the time of the read.
- R5: An event pulse sets its flag on the next clock edge: bus error bit 0, start bit 1, end bit 2, stop bit 3, request-after-start bit 4, end-of-receive bit 9.
- R6: When an event pulse and a host write that would clear the same flag fall in the same cycle, the flag ends up set.
- R7: A write with bit 31 set clears the stopped flag and raises `launch` for exactly one cycle after the write edge; `launch_fetch` rises with it only if bit 30 of that write is 0.
- R8: A write with both bit 31 (run) and bit 22 (mask-run) clear sets the stopped flag.
- R9: Write bit 24 clears compare status (bit 10) and write bit 25 sets it; with both set, compare status ends up set.
- R10: A channel interrupts when stopped is set with bit 29 set, end-of-receive is set with bit 28 set, request-after-start is set with bit 23 set, or start or end is set; bus error never interrupts.
- R11: `irq` is the OR of all channels' interrupt conditions; the summary word has bit c set exactly when channel c interrupts.
- R12: `ch_run`, `ch_nodesc`, `ch_eor_stop`, `ch_eor_jump` and `ch_cmp` follow stored bits 31, 30, 26, 27 and 10 of each channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Word index for read and write |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for `host_addr` (combinational) |
| ev_buserr | input | NUM_CH | Bus error event pulses |
| ev_start | input | NUM_CH | Start event pulses |
| ev_end | input | NUM_CH | End event pulses |
| ev_stop | input | NUM_CH | Stop event pulses |
| ev_ras | input | NUM_CH | Request-after-start event pulses |
| ev_eor | input | NUM_CH | End-of-receive event pulses |
| req_active | input | NUM_CH | Request pending level per channel |
| ch_run | output | NUM_CH | Run control per channel |
| ch_nodesc | output | NUM_CH | No-descriptor-fetch control per channel |
| ch_eor_stop | output | NUM_CH | End-of-receive stop enable per channel |
| ch_eor_jump | output | NUM_CH | End-of-receive jump enable per channel |
| ch_cmp | output | NUM_CH | Compare status per channel |
| launch | output | NUM_CH | One-cycle channel launch pulse |
| launch_fetch | output | NUM_CH | Launch needs a descriptor fetch |
| irq | output | 1 | Combined interrupt line |

## Verification
Two things can land on the same flag in one cycle: an engine event setting it and a host write clearing it. This applies to start with its write-one-to-clear bit and to stop with a run write. The bench provokes this by driving the event pulse and the write in the same cycle. The flag must then read back as set. Each case is followed by an ordinary clear, which shows that the flag can still be cleared afterwards.

// File: rtl/dmacs_pkg.sv
`timescale 1ns/1ps
// dmacs_pkg: bit positions and shared state types for the DMA channel
// status bank. Assumes a 32-bit channel word with fixed field positions.
package dmacs_pkg;

    localparam int B_BERR    = 0;
    localparam int B_START   = 1;
    localparam int B_END     = 2;
    localparam int B_STOP    = 3;
    localparam int B_RAS     = 4;
    localparam int B_REQ     = 8;
    localparam int B_EOR     = 9;
    localparam int B_CMP     = 10;
    localparam int B_MASKRUN = 22;
    localparam int B_RASIE   = 23;
    localparam int B_CMPCLR  = 24;
    localparam int B_CMPSET  = 25;
    localparam int B_EORSTOP = 26;
    localparam int B_EORJMP  = 27;
    localparam int B_EORIE   = 28;
    localparam int B_STOPIE  = 29;
    localparam int B_NODESC  = 30;
    localparam int B_RUN     = 31;

    // Stored control bits (loaded on every write)
    typedef struct packed {
        logic run;
        logic nodesc;
        logic stop_ie;
        logic eor_ie;
        logic eor_jump;
        logic eor_stop;
        logic ras_ie;
    } ctl_t;

    // Stored status flags
    typedef struct packed {
        logic cmp;
        logic eor;
        logic ras;
        logic stopped;
        logic end_f;
        logic start_f;
        logic berr;
    } sts_t;

    // Event pulses from one channel engine
    typedef struct packed {
        logic berr;
        logic start_f;
        logic end_f;
        logic stopped;
        logic ras;
        logic eor;
    } ev_t;

    // Assemble the readable channel word
    function automatic logic [31:0] pack_word(ctl_t c, sts_t s, logic req);
        logic [31:0] w;
        w            = '0;
        w[B_BERR]    = s.berr;
        w[B_START]   = s.start_f;
        w[B_END]     = s.end_f;
        w[B_STOP]    = s.stopped;
        w[B_RAS]     = s.ras;
        w[B_REQ]     = req;
        w[B_EOR]     = s.eor;
        w[B_CMP]     = s.cmp;
        w[B_RASIE]   = c.ras_ie;
        w[B_EORSTOP] = c.eor_stop;
        w[B_EORJMP]  = c.eor_jump;
        w[B_EORIE]   = c.eor_ie;
        w[B_STOPIE]  = c.stop_ie;
        w[B_NODESC]  = c.nodesc;
        w[B_RUN]     = c.run;
        return w;
    endfunction

endpackage

// File: rtl/dmacs_channel.sv
`timescale 1ns/1ps
// dmacs_channel: control/status word of one DMA channel.
// Handles host writes (control load, write-one-to-clear flags, run and
// compare side effects) and engine event pulses. Events win over a clear
// landing in the same cycle. Assumes events are single-cycle pulses.
module dmacs_channel
    import dmacs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_sel,
    input  logic [31:0] wdata,
    input  ev_t         ev,
    input  logic        req_active,
    output logic [31:0] rd_word,
    output ctl_t        ctl_q,
    output sts_t        sts_q,
    output logic        launch,
    output logic        launch_fetch
);

    ctl_t ctl_n;
    sts_t sts_n;
    logic go_n;
    logic fetch_n;

    // Next-state: host write effects first, then events override
    always_comb begin
        ctl_n   = ctl_q;
        sts_n   = sts_q;
        go_n    = 1'b0;
        fetch_n = 1'b0;
        if (wr_sel) begin
            sts_n.berr    = sts_q.berr    & ~wdata[B_BERR];
            sts_n.start_f = sts_q.start_f & ~wdata[B_START];
            sts_n.end_f   = sts_q.end_f   & ~wdata[B_END];
            sts_n.eor     = sts_q.eor     & ~wdata[B_EOR];
            ctl_n.run      = wdata[B_RUN];
            ctl_n.nodesc   = wdata[B_NODESC];
            ctl_n.stop_ie  = wdata[B_STOPIE];
            ctl_n.eor_ie   = wdata[B_EORIE];
            ctl_n.eor_jump = wdata[B_EORJMP];
            ctl_n.eor_stop = wdata[B_EORSTOP];
            ctl_n.ras_ie   = wdata[B_RASIE];
            if (wdata[B_RUN]) begin
                sts_n.stopped = 1'b0;
                go_n          = 1'b1;
                fetch_n       = ~wdata[B_NODESC];
            end else if (!wdata[B_MASKRUN]) begin
                sts_n.stopped = 1'b1;
            end
            if (wdata[B_CMPCLR]) sts_n.cmp = 1'b0;
            if (wdata[B_CMPSET]) sts_n.cmp = 1'b1;
        end
        if (ev.berr)    sts_n.berr    = 1'b1;
        if (ev.start_f) sts_n.start_f = 1'b1;
        if (ev.end_f)   sts_n.end_f   = 1'b1;
        if (ev.stopped) sts_n.stopped = 1'b1;
        if (ev.ras)     sts_n.ras     = 1'b1;
        if (ev.eor)     sts_n.eor     = 1'b1;
    end

    // State registers with reset to "stopped only"
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q         <= '0;
            sts_q         <= '0;
            sts_q.stopped <= 1'b1;
            launch        <= 1'b0;
            launch_fetch  <= 1'b0;
        end else begin
            ctl_q         <= ctl_n;
            sts_q         <= sts_n;
            launch        <= go_n;
            launch_fetch  <= fetch_n;
        end
    end

    // Readable word with live request-pending bit
    assign rd_word = pack_word(ctl_q, sts_q, req_active);

    p_start_evt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev.start_f |=> sts_q.start_f);

    p_stop_evt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev.stopped |=> sts_q.stopped);

    p_eor_beats_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && wdata[B_EOR] && ev.eor) |=> sts_q.eor);

    p_launch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && wdata[B_RUN]) |=>
            (launch && (launch_fetch == !$past(wdata[B_NODESC])) && !sts_q.stopped)
            || $past(ev.stopped));

    p_no_spurious_launch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_sel && wdata[B_RUN]) |=> !launch && !launch_fetch);

    p_mask_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && !wdata[B_RUN] && !wdata[B_MASKRUN]) |=> sts_q.stopped);

    p_cmp_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && wdata[B_CMPSET]) |=> sts_q.cmp);

    p_cmp_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && wdata[B_CMPCLR] && !wdata[B_CMPSET]) |=> !sts_q.cmp);

endmodule

// File: rtl/dmacs_irq_gate.sv
`timescale 1ns/1ps
// dmacs_irq_gate: applies each source's enable rule per channel and
// forms the per-channel summary and the combined interrupt line.
// Assumes flags and enables come straight from channel registers.
module dmacs_irq_gate #(
    parameter int NUM_CH = 8
) (
    input  logic [NUM_CH-1:0] stopped,
    input  logic [NUM_CH-1:0] stop_ie,
    input  logic [NUM_CH-1:0] eor,
    input  logic [NUM_CH-1:0] eor_ie,
    input  logic [NUM_CH-1:0] ras,
    input  logic [NUM_CH-1:0] ras_ie,
    input  logic [NUM_CH-1:0] start_f,
    input  logic [NUM_CH-1:0] end_f,
    output logic [NUM_CH-1:0] summary,
    output logic              irq
);

    // Per-channel gating of each interrupt source
    for (genvar c = 0; c < NUM_CH; c++) begin : g_gate
        assign summary[c] = (stopped[c] & stop_ie[c])
                          | (eor[c]     & eor_ie[c])
                          | (ras[c]     & ras_ie[c])
                          | start_f[c]
                          | end_f[c];
    end

    // Combined interrupt line
    assign irq = |summary;

endmodule

// File: rtl/dmacs_read_mux.sv
`timescale 1ns/1ps
// dmacs_read_mux: selects the host read word from the channel words or
// the interrupt summary. Unmapped indices read as zero.
module dmacs_read_mux #(
    parameter int NUM_CH   = 8,
    parameter int ADDR_W   = 6,
    parameter int SUM_ADDR = 60
) (
    input  logic [ADDR_W-1:0]      addr,
    input  logic [NUM_CH*32-1:0]   words,
    input  logic [NUM_CH-1:0]      summary,
    output logic [31:0]            rdata
);

    localparam logic [ADDR_W-1:0] SUM_IDX = ADDR_W'(SUM_ADDR);

    // Address decode for host reads
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == ADDR_W'(i)) rdata = words[i*32 +: 32];
        end
        if (addr == SUM_IDX) rdata = 32'(summary);
    end

endmodule

// File: rtl/dma_chan_status_bank.sv
`timescale 1ns/1ps
// dma_chan_status_bank: top of the DMA channel status and interrupt bank.
// One dmacs_channel per channel, an interrupt gate and a read mux.
// Assumes NUM_CH <= 32 and SUM_ADDR >= NUM_CH.
module dma_chan_status_bank
    import dmacs_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int ADDR_W   = 6,
    parameter int SUM_ADDR = 60
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_wr,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [31:0]         host_wdata,
    output logic [31:0]         host_rdata,
    input  logic [NUM_CH-1:0]   ev_buserr,
    input  logic [NUM_CH-1:0]   ev_start,
    input  logic [NUM_CH-1:0]   ev_end,
    input  logic [NUM_CH-1:0]   ev_stop,
    input  logic [NUM_CH-1:0]   ev_ras,
    input  logic [NUM_CH-1:0]   ev_eor,
    input  logic [NUM_CH-1:0]   req_active,
    output logic [NUM_CH-1:0]   ch_run,
    output logic [NUM_CH-1:0]   ch_nodesc,
    output logic [NUM_CH-1:0]   ch_eor_stop,
    output logic [NUM_CH-1:0]   ch_eor_jump,
    output logic [NUM_CH-1:0]   ch_cmp,
    output logic [NUM_CH-1:0]   launch,
    output logic [NUM_CH-1:0]   launch_fetch,
    output logic                irq
);

    localparam logic [ADDR_W-1:0] SUM_IDX = ADDR_W'(SUM_ADDR);

    logic [NUM_CH*32-1:0] words;
    logic [NUM_CH-1:0]    stopped_v, stop_ie_v, eor_v, eor_ie_v;
    logic [NUM_CH-1:0]    ras_v, ras_ie_v, start_v, end_v;
    logic [NUM_CH-1:0]    summary;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ctl_t ctl;
        sts_t sts;
        ev_t  ev;
        logic sel;

        // Per-channel write decode and event bundling
        assign sel = host_wr && (host_addr == ADDR_W'(c));
        assign ev  = '{berr: ev_buserr[c], start_f: ev_start[c], end_f: ev_end[c],
                       stopped: ev_stop[c], ras: ev_ras[c], eor: ev_eor[c]};

        dmacs_channel u_chan (
            .clk          (clk),
            .rst_n        (rst_n),
            .wr_sel       (sel),
            .wdata        (host_wdata),
            .ev           (ev),
            .req_active   (req_active[c]),
            .rd_word      (words[c*32 +: 32]),
            .ctl_q        (ctl),
            .sts_q        (sts),
            .launch       (launch[c]),
            .launch_fetch (launch_fetch[c])
        );

        // Fan stored bits out to engines and interrupt gate
        assign ch_run[c]      = ctl.run;
        assign ch_nodesc[c]   = ctl.nodesc;
        assign ch_eor_stop[c] = ctl.eor_stop;
        assign ch_eor_jump[c] = ctl.eor_jump;
        assign ch_cmp[c]      = sts.cmp;
        assign stopped_v[c]   = sts.stopped;
        assign stop_ie_v[c]   = ctl.stop_ie;
        assign eor_v[c]       = sts.eor;
        assign eor_ie_v[c]    = ctl.eor_ie;
        assign ras_v[c]       = sts.ras;
        assign ras_ie_v[c]    = ctl.ras_ie;
        assign start_v[c]     = sts.start_f;
        assign end_v[c]       = sts.end_f;
    end

    dmacs_irq_gate #(.NUM_CH(NUM_CH)) u_gate (
        .stopped (stopped_v),
        .stop_ie (stop_ie_v),
        .eor     (eor_v),
        .eor_ie  (eor_ie_v),
        .ras     (ras_v),
        .ras_ie  (ras_ie_v),
        .start_f (start_v),
        .end_f   (end_v),
        .summary (summary),
        .irq     (irq)
    );

    dmacs_read_mux #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .SUM_ADDR(SUM_ADDR)) u_rmux (
        .addr    (host_addr),
        .words   (words),
        .summary (summary),
        .rdata   (host_rdata)
    );

    p_start_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(start_v | end_v)) |-> irq);

    p_irq_summary_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == SUM_IDX) |-> (irq == (host_rdata != 32'h0)));

    p_quiet_after_reset_r1: assert property (@(posedge clk)
        $past(!rst_n) && !rst_n |=> !irq && !(|launch));

endmodule

// File: tb/dma_chan_status_bank_test.sv
`timescale 1ns/1ps
module dma_chan_status_bank_test;

    localparam int NUM_CH = 8;
    localparam int ADDR_W = 6;
    localparam logic [5:0] SUM = 6'h3C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_wr = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [NUM_CH-1:0] ev_buserr = '0, ev_start = '0, ev_end = '0;
    logic [NUM_CH-1:0] ev_stop = '0, ev_ras = '0, ev_eor = '0, req_active = '0;
    logic [NUM_CH-1:0] ch_run, ch_nodesc, ch_eor_stop, ch_eor_jump, ch_cmp;
    logic [NUM_CH-1:0] launch, launch_fetch;
    logic irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] rd;

    always #2.5 clk = ~clk;

    dma_chan_status_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .SUM_ADDR(60)) uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ev_buserr(ev_buserr), .ev_start(ev_start), .ev_end(ev_end),
        .ev_stop(ev_stop), .ev_ras(ev_ras), .ev_eor(ev_eor),
        .req_active(req_active), .ch_run(ch_run), .ch_nodesc(ch_nodesc),
        .ch_eor_stop(ch_eor_stop), .ch_eor_jump(ch_eor_jump), .ch_cmp(ch_cmp),
        .launch(launch), .launch_fetch(launch_fetch), .irq(irq)
    );

    typedef struct packed {
        logic [5:0]  addr;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic        exp_irq;
    } row_t;

    // Write a channel, then expect its readback and the irq level
    localparam row_t TBL [10] = '{
        '{6'd0, 32'h0000_0000, 32'h0000_0008, 1'b0},  // R8
        '{6'd1, 32'h2000_0000, 32'h2000_0008, 1'b1},  // R10 stop gated on
        '{6'd1, 32'h0040_0000, 32'h0000_0008, 1'b0},  // R2 mask-run not stored
        '{6'd2, 32'h8000_0000, 32'h8000_0000, 1'b0},  // R7 run clears stopped
        '{6'd2, 32'h4040_0000, 32'h4000_0000, 1'b0},  // R2 run reloaded to 0
        '{6'd3, 32'h0240_0000, 32'h0000_0408, 1'b0},  // R9 set compare
        '{6'd3, 32'h0140_0000, 32'h0000_0008, 1'b0},  // R9 clear compare
        '{6'd3, 32'h0340_0000, 32'h0000_0408, 1'b0},  // R9 both: set wins
        '{6'd4, 32'hFCC0_0000, 32'hFC80_0000, 1'b0},  // R2 all control bits
        '{6'd4, 32'h0000_0000, 32'h0000_0008, 1'b0}   // R2 cleared, R8
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic read_reg(input logic [5:0] a, output logic [31:0] v);
        host_addr = a;
        #0.5;
        v = host_rdata;
    endtask

    // One clock cycle of stimulus: optional write plus event pulses
    task automatic cycle(input logic wr, input logic [5:0] a, input logic [31:0] d,
                         input logic [7:0] s, input logic [7:0] e, input logic [7:0] eo,
                         input logic [7:0] st, input logic [7:0] ra, input logic [7:0] be);
        @(negedge clk);
        host_wr = wr; host_addr = a; host_wdata = d;
        ev_start = s; ev_end = e; ev_eor = eo; ev_stop = st; ev_ras = ra; ev_buserr = be;
        @(posedge clk);
        #1;
        host_wr = 1'b0;
        ev_start = '0; ev_end = '0; ev_eor = '0; ev_stop = '0; ev_ras = '0; ev_buserr = '0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        cycle(1'b1, a, d, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1 reset state
        for (int c = 0; c < NUM_CH; c++) begin
            read_reg(6'(c), rd);
            check("R1 reset word", rd, 32'h0000_0008);
        end
        read_reg(SUM, rd);
        check("R1 reset summary", rd, 32'h0);
        check("R1 reset irq", 32'(irq), 32'h0);

        // Table walk
        for (int i = 0; i < 10; i++) begin
            wr(TBL[i].addr, TBL[i].wdata);
            read_reg(TBL[i].addr, rd);
            check("R2/R7/R8/R9 table word", rd, TBL[i].exp);
            check("R10/R11 table irq", 32'(irq), 32'(TBL[i].exp_irq));
        end

        // R4 request pending bit follows live input
        req_active[5] = 1'b1;
        read_reg(6'd5, rd);
        check("R4 req high", rd, 32'h0000_0108);
        req_active[5] = 1'b0;
        read_reg(6'd5, rd);
        check("R4 req low", rd, 32'h0000_0008);

        // R5 start event interrupts ungated, R3 W1C clears it
        cycle(1'b0, 6'd0, 32'h0, 8'h40, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0);
        read_reg(6'd6, rd);
        check("R5 start flag", rd, 32'h0000_000A);
        read_reg(SUM, rd);
        check("R11 summary start", rd, 32'h0000_0040);
        wr(6'd6, 32'h0040_0000);
        read_reg(6'd6, rd);
        check("R3 write 0 keeps start", rd, 32'h0000_000A);
        wr(6'd6, 32'h0040_0002);
        read_reg(6'd6, rd);
        check("R3 start cleared", rd, 32'h0000_0008);
        check("R3 irq after clear", 32'(irq), 32'h0);

        // End event
        cycle(1'b0, 6'd0, 32'h0, 8'h0, 8'h40, 8'h0, 8'h0, 8'h0, 8'h0);
        read_reg(6'd6, rd);
        check("R5 end flag", rd, 32'h0000_000C);
        check("R10 end irq", 32'(irq), 32'h1);
        wr(6'd6, 32'h0040_0004);
        read_reg(6'd6, rd);
        check("R3 end cleared", rd, 32'h0000_0008);

        // Bus error never interrupts
        cycle(1'b0, 6'd0, 32'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h40);
        read_reg(6'd6, rd);
        check("R5 berr flag", rd, 32'h0000_0009);
        check("R10 berr no irq", 32'(irq), 32'h0);
        wr(6'd6, 32'h0040_0001);
        read_reg(6'd6, rd);
        check("R3 berr cleared", rd, 32'h0000_0008);

        // End-of-receive gating
        cycle(1'b0, 6'd0, 32'h0, 8'h0, 8'h0, 8'h40, 8'h0, 8'h0, 8'h0);
        read_reg(6'd6, rd);
        check("R5 eor flag", rd, 32'h0000_0208);
        check("R10 eor gated off", 32'(irq), 32'h0);
        wr(6'd6, 32'h1040_0000);
        read_reg(6'd6, rd);
        check("R10 eor enabled word", rd, 32'h1000_0208);
        check("R10 eor gated on", 32'(irq), 32'h1);
        wr(6'd6, 32'h1040_0200);
        read_reg(6'd6, rd);
        check("R3 eor cleared", rd, 32'h1000_0008);
        check("R3 eor irq gone", 32'(irq), 32'h0);

        // Request-after-start gating on channel 5
        wr(6'd5, 32'h00C0_0000);
        cycle(1'b0, 6'd0, 32'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h20, 8'h0);
        read_reg(6'd5, rd);
        check("R5 ras flag", rd, 32'h0080_0018);
        check("R10 ras irq", 32'(irq), 32'h1);
        wr(6'd5, 32'h0040_0001);
        read_reg(6'd5, rd);
        check("R3 ras not cleared", rd, 32'h0000_0018);
        check("R10 ras gated off", 32'(irq), 32'h0);

        // R6 event beats W1C in the same cycle
        cycle(1'b1, 6'd6, 32'h1040_0000 | 32'h2, 8'h40, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0);
        read_reg(6'd6, rd);
        check("R6 start survives clear", rd, 32'h1000_000A);
        wr(6'd6, 32'h0040_0002);
        read_reg(6'd6, rd);
        check("R6 later clear works", rd, 32'h0000_0008);

        // R6 stop event beats run write
        cycle(1'b1, 6'd0, 32'h8000_0000, 8'h0, 8'h0, 8'h0, 8'h01, 8'h0, 8'h0);
        read_reg(6'd0, rd);
        check("R6 stop survives run", rd, 32'h8000_0008);

        // R7 launch with and without fetch; R12 outputs
        wr(6'd0, 32'h8000_0000);
        check("R7 launch", 32'(launch), 32'h01);
        check("R7 fetch", 32'(launch_fetch), 32'h01);
        read_reg(6'd0, rd);
        check("R7 stopped cleared", rd, 32'h8000_0000);
        wr(6'd0, 32'hC000_0000);
        check("R7 launch nodesc", 32'(launch), 32'h01);
        check("R7 no fetch", 32'(launch_fetch), 32'h00);
        check("R12 run out", 32'(ch_run), 32'h01);
        check("R12 nodesc out", 32'(ch_nodesc), 32'h05);
        @(posedge clk); #1;
        check("R7 launch one cycle", 32'(launch), 32'h00);

        // R5 stop event on idle channel 2
        cycle(1'b0, 6'd0, 32'h0, 8'h0, 8'h0, 8'h0, 8'h04, 8'h0, 8'h0);
        read_reg(6'd2, rd);
        check("R5 stop flag", rd, 32'h4000_0008);

        // R12 end-of-receive controls and compare output
        wr(6'd7, 32'h0C40_0000);
        check("R12 eor stop out", 32'(ch_eor_stop), 32'h80);
        check("R12 eor jump out", 32'(ch_eor_jump), 32'h80);
        check("R12 cmp out", 32'(ch_cmp), 32'h08);

        // R11 two channels at once
        cycle(1'b0, 6'd0, 32'h0, 8'h0A, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0);
        read_reg(SUM, rd);
        check("R11 summary two", rd, 32'h0000_000A);
        check("R11 irq two", 32'(irq), 32'h1);
        wr(6'd1, 32'h0040_0002);
        read_reg(SUM, rd);
        check("R11 summary one", rd, 32'h0000_0008);
        wr(6'd3, 32'h0040_0002);
        check("R11 irq idle", 32'(irq), 32'h0);
        read_reg(6'd3, rd);
        check("R3 cmp kept", rd, 32'h0000_0408);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule